// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This peripheral produces four independent pulse-width modulated outputs from one input clock. Software programs it through a plain 32-bit register interface: one shared control word, a period count and an active-time (duty) count for each channel, and one shared word that packs the four 6-bit clock dividers. Every channel slows the input clock by its own divider, counts period ticks, and holds its output in the active state for the first duty-count ticks of each period.

Each channel has its own enable, polarity and drive-style bits. On the cycle that follows the enable going from 0 to 1, the channel takes a snapshot of its divider, period and duty values and restarts its counters. Any register change made while the channel runs waits until software clears and sets the enable again. In push-pull style the output-enable pin is always on. In open-drain style it turns on only while the channel drives low. Reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_wr` is high. The register port has no back-pressure because it accepts one access per cycle, and no stream interface exists.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset, every register reads zero, and each output sits at its inactive level for polarity 0, so `pwm_out` is 1 and `pwm_oe` is 1.
- R2: The register map uses these byte offsets:
  - control at 0x00, with enable of channel c in bit c, polarity in bit 8+c and drive style in bit 15+c;
  - period of channel c at 0x04+8c, in bits 15:0;
  - duty of channel c at 0x08+8c, in bits 15:0;
  - dividers at 0x24.
  Unused bits and unmapped offsets read zero.
- R3: The divider field of channel c is bits [(3-c)*6 +: 6] of the word at 0x24, so channel 0 uses bits 23:18 and channel 3 uses bits 5:0.
- R4: Take k as the number of cycles since the first cycle after the enable-setting write, starting at k = 0. An armed channel is active when (k / (div+1)) mod period < duty, which gives a period of (div+1)·period cycles.
- R5: A duty count of 0 keeps the output inactive. A duty count at or above the period keeps it active.
- R6: A latched period count below 2 behaves as 2.
- R7: Polarity 1 drives `pwm_out` high while active and low while inactive. Polarity 0 inverts this. A polarity write takes effect at once.
- R8: Drive style 0 holds `pwm_oe` at 1. Drive style 1 makes `pwm_oe` equal to the inverse of `pwm_out`.
- R9: Writes to the period, duty or divider registers of a running channel leave its waveform unchanged until it is re-armed.
- R10: A channel whose enable is 0 shows its inactive level from the cycle after the clearing write. In the cycle after an enable-setting write it is still inactive.
- R11: A clearing write followed by a setting write on the very next cycle re-arms the channel with the values current at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 4 | Output level per channel |
| pwm_oe | output | 4 | Output-enable per channel |

## Verification
Two events can land on the same cycle: a register write aimed at a running channel, and that channel wrapping its period or divider count. The bench rewrites period, duty and divider values at arbitrary points in free-running waveforms, including the cycle where a count rolls over. It then compares every output, every cycle, against a model that keeps the previously latched values. The reverse case is also covered: a clearing write and a setting write on back-to-back cycles must restart all four counters together with the new values, and the first active cycle must land where the model predicts.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int NCH      = 4;
  localparam int DATA_W   = 32;
  localparam int EN_LSB   = 0;
  localparam int POL_LSB  = 8;
  localparam int DRV_LSB  = 15;
  localparam int CTRL_OFS = 'h00;
  localparam int DIV_OFS  = 'h24;

  function automatic int period_ofs(int ch);
    return 'h04 + 8 * ch;
  endfunction

  function automatic int duty_ofs(int ch);
    return 'h08 + 8 * ch;
  endfunction
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NCH-1:0]             en,
  output logic [NCH-1:0]             pol,
  output logic [NCH-1:0]             drv,
  output logic [NCH-1:0][CNT_W-1:0]  per,
  output logic [NCH-1:0][CNT_W-1:0]  duty,
  output logic [NCH-1:0][DIV_W-1:0]  div
);
  localparam int DIVW_TOT = NCH * DIV_W;

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:DIVW_TOT];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      pol  <= '0;
      drv  <= '0;
      per  <= '0;
      duty <= '0;
      div  <= '0;
    end else if (wr) begin
      if (hit(addr, CTRL_OFS)) begin
        en  <= wdata[EN_LSB  +: NCH];
        pol <= wdata[POL_LSB +: NCH];
        drv <= wdata[DRV_LSB +: NCH];
      end
      for (int c = 0; c < NCH; c++) begin
        if (hit(addr, period_ofs(c))) per[c]  <= wdata[CNT_W-1:0];
        if (hit(addr, duty_ofs(c)))   duty[c] <= wdata[CNT_W-1:0];
        if (hit(addr, DIV_OFS))       div[c]  <= wdata[(NCH-1-c)*DIV_W +: DIV_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit(addr, CTRL_OFS)) begin
      rdata[EN_LSB  +: NCH] = en;
      rdata[POL_LSB +: NCH] = pol;
      rdata[DRV_LSB +: NCH] = drv;
    end
    for (int c = 0; c < NCH; c++) begin
      if (hit(addr, period_ofs(c))) rdata[CNT_W-1:0] = per[c];
      if (hit(addr, duty_ofs(c)))   rdata[CNT_W-1:0] = duty[c];
      if (hit(addr, DIV_OFS))       rdata[(NCH-1-c)*DIV_W +: DIV_W] = div[c];
    end
  end
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 6,
  parameter int MIN_PER = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic             drv,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             armed,
  output logic             lvl,
  output logic             oe
);
  localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(MIN_PER);

  logic [DIV_W-1:0] div_l, div_cnt;
  logic [CNT_W-1:0] per_l, duty_l, tick;
  logic             rise, active;

  assign rise = en & ~armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      div_l   <= '0;
      per_l   <= PER_FLOOR;
      duty_l  <= '0;
      div_cnt <= '0;
      tick    <= '0;
    end else begin
      armed <= en;
      if (rise) begin
        div_l   <= div_i;
        per_l   <= (per_i < PER_FLOOR) ? PER_FLOOR : per_i;
        duty_l  <= duty_i;
        div_cnt <= '0;
        tick    <= '0;
      end else if (en) begin
        if (div_cnt == div_l) begin
          div_cnt <= '0;
          tick    <= (tick == per_l - 1'b1) ? '0 : tick + 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign active = en & armed & (tick < duty_l);
  assign lvl    = pol ? active : ~active;
  assign oe     = drv ? ~lvl : 1'b1;
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [3:0]        pwm_out,
  output logic [3:0]        pwm_oe
);
  logic [NCH-1:0]            en_w, pol_w, drv_w, armed_w;
  logic [NCH-1:0][CNT_W-1:0] per_w, duty_w;
  logic [NCH-1:0][DIV_W-1:0] div_w;

  pwm4_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .en    (en_w),
    .pol   (pol_w),
    .drv   (drv_w),
    .per   (per_w),
    .duty  (duty_w),
    .div   (div_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm4_chan #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_w[c]),
      .pol    (pol_w[c]),
      .drv    (drv_w[c]),
      .div_i  (div_w[c]),
      .per_i  (per_w[c]),
      .duty_i (duty_w[c]),
      .armed  (armed_w[c]),
      .lvl    (pwm_out[c]),
      .oe     (pwm_oe[c])
    );
  end
endmodule

// File: rtl/pwm4_chk.sv
module pwm4_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_rdata,
  input logic [3:0]            ctrl_en,
  input logic [3:0]            ctrl_pol,
  input logic [3:0]            ctrl_drv,
  input logic [3:0][CNT_W-1:0] duty_reg,
  input logic [3:0]            armed,
  input logic [3:0]            pwm_out,
  input logic [3:0]            pwm_oe
);
  p_ctrl_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |->
      (bus_rdata[31:19] == '0 && bus_rdata[14:12] == '0 && bus_rdata[7:4] == '0));

  p_div_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h24)) |-> (bus_rdata[31:24] == '0));

  for (genvar c = 0; c < 4; c++) begin : g_a
    p_pushpull_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_drv[c] |-> pwm_oe[c]);

    p_opendrain_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_drv[c] |-> (pwm_oe[c] == !pwm_out[c]));

    p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en[c] |-> (pwm_out[c] == !ctrl_pol[c]));

    p_first_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en[c] && !armed[c] && duty_reg[c] != '0 && !bus_wr) |=>
        (pwm_out[c] == ctrl_pol[c]));
  end
endmodule

bind pwm4_ctrl pwm4_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ctrl_en   (en_w),
  .ctrl_pol  (pol_w),
  .ctrl_drv  (drv_w),
  .duty_reg  (duty_w),
  .armed     (armed_w),
  .pwm_out   (pwm_out),
  .pwm_oe    (pwm_oe)
);

// File: tb/pwm4_ctrl_tb.sv
module pwm4_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out, pwm_oe;

  always #5 clk = ~clk;

  pwm4_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R1";

  // bench shadow of programmed values and per-channel latched model
  logic [3:0]  sh_en = '0, sh_pol = '0, sh_drv = '0;
  int          sh_per[4], sh_dut[4];
  logic [31:0] sh_div = '0;
  int          l_per[4], l_dut[4], l_div[4], k[4];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_lvl(int c);
    logic act;
    act = sh_en[c] && k[c] >= 0 &&
          (((k[c] / (l_div[c] + 1)) % l_per[c]) < l_dut[c]);
    return sh_pol[c] ? act : !act;
  endfunction

  task automatic check_all();
    for (int c = 0; c < 4; c++) begin
      logic eo, eoe;
      eo  = exp_lvl(c);
      eoe = sh_drv[c] ? !eo : 1'b1;
      check(pwm_out[c] == eo, $sformatf("%s/R7 out ch%0d", tag, c), pwm_out[c], eo);
      check(pwm_oe[c] == eoe, $sformatf("R8 oe ch%0d", c), pwm_oe[c], eoe);
    end
  endtask

  task automatic step_k();
    for (int c = 0; c < 4; c++) if (sh_en[c]) k[c]++;
  endtask

  // called at a negedge; returns at the next negedge after the write edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [3:0] rise;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    rise = '0;
    if (a == 6'h00) begin
      rise   = d[3:0] & ~sh_en;
      sh_en  = d[3:0];
      sh_pol = d[11:8];
      sh_drv = d[18:15];
    end
    if (a == 6'h24) sh_div = d;
    for (int c = 0; c < 4; c++) begin
      if (a == 6'(4 + 8*c)) sh_per[c] = int'(d[15:0]);
      if (a == 6'(8 + 8*c)) sh_dut[c] = int'(d[15:0]);
      if (rise[c]) begin
        l_per[c] = (sh_per[c] < 2) ? 2 : sh_per[c];
        l_dut[c] = sh_dut[c];
        l_div[c] = int'((sh_div >> ((3 - c) * 6)) & 32'h3f);
        k[c] = -1;
      end
    end
    check_all();
    step_k();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      step_k();
    end
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic cfg_ch(input int c, input int p, input int d);
    wr(6'(4 + 8*c), 32'(p));
    wr(6'(8 + 8*c), 32'(d));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin
      sh_per[c] = 0; sh_dut[c] = 0; l_per[c] = 2; l_dut[c] = 0; l_div[c] = 0; k[c] = -1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of registers and outputs
    tag = "R1";
    check_all();
    rd_chk(6'h00, 32'h0, "R1 ctrl");
    for (int c = 0; c < 4; c++) begin
      rd_chk(6'(4 + 8*c), 32'h0, "R1 period");
      rd_chk(6'(8 + 8*c), 32'h0, "R1 duty");
    end
    rd_chk(6'h24, 32'h0, "R1 div");

    // R2: map and masking of unused bits
    tag = "R2";
    wr(6'h00, 32'hFFFF_FFF0);
    rd_chk(6'h00, 32'h0007_8F00, "R2 ctrl mask");
    wr(6'h14, 32'hDEAD_ABCD);
    rd_chk(6'h14, 32'h0000_ABCD, "R2 period ch2");
    wr(6'h20, 32'hFFFF_1234);
    rd_chk(6'h20, 32'h0000_1234, "R2 duty ch3");
    rd_chk(6'h28, 32'h0, "R2 unmapped");
    // R3: divider field placement, reversed channel order
    wr(6'h24, 32'hFFFF_FFFF);
    rd_chk(6'h24, 32'h00FF_FFFF, "R3 div mask");
    wr(6'h24, (32'd2 << 18) | 32'd5);
    rd_chk(6'h24, 32'h0008_0005, "R3 div fields");
    wr(6'h00, 32'h0);

    // R3/R4: ch0 divider 2, ch3 divider 5, ch1/ch2 divider 0
    tag = "R4";
    for (int c = 0; c < 4; c++) cfg_ch(c, 4, 2);
    wr(6'h00, 32'h0000_0F0F);
    run(80);

    // R5: duty 0 and duty >= period; R6: period below 2
    tag = "R5";
    wr(6'h00, 32'h0000_0F00);
    wr(6'h24, 32'h0);
    cfg_ch(0, 5, 0);
    cfg_ch(1, 5, 5);
    cfg_ch(2, 3, 200);
    tag = "R6";
    cfg_ch(3, 1, 1);
    wr(6'h00, 32'h0000_0F0F);
    run(30);

    // R9: writes to running channels are held off; R7 live polarity change
    tag = "R9";
    cfg_ch(0, 3, 1);
    cfg_ch(3, 7, 4);
    wr(6'h24, 32'h00FF_FFFF);
    wr(6'h00, 32'h0003_870F);
    run(20);
    // R11: clear then set on back-to-back cycles picks up new values
    tag = "R11";
    wr(6'h00, 32'h0003_8700);
    wr(6'h00, 32'h0003_870F);
    run(150);
    // R10: disable drives inactive level
    tag = "R10";
    wr(6'h00, 32'h0000_0500);
    run(5);

    // random configurations, with mid-run rewrites (R9) and re-arms (R11)
    for (int it = 0; it < 8; it++) begin
      logic [31:0] ctl;
      tag = "R4";
      wr(6'h24, $urandom & 32'h00FF_FFFF & 32'h00C3_0C30 ^ 32'h0);
      for (int c = 0; c < 4; c++) cfg_ch(c, $urandom_range(0, 12), $urandom_range(0, 14));
      ctl = {13'h0, 4'($urandom), 3'h0, 4'($urandom), 4'h0, 4'($urandom) | 4'h1};
      wr(6'h00, ctl);
      run($urandom_range(20, 60));
      tag = "R9";
      for (int c = 0; c < 4; c++) cfg_ch(c, $urandom_range(2, 9), $urandom_range(0, 9));
      wr(6'h24, $urandom & 32'h0041_0410);
      run($urandom_range(10, 40));
      tag = "R11";
      wr(6'h00, ctl & ~32'hF);
      wr(6'h00, ctl | 32'hF);
      run($urandom_range(40, 120));
      tag = "R10";
      wr(6'h00, ctl & ~32'hF);
      run(3);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule